// File: doc/BRIEF.md
# Video RAM row-transfer controller

This block manages the transfers between the row array of a dual-port video memory and its serial access register (SAM). When the row strobe falls, the block samples four control levels: transfer gate, write enable, serial enable and special function. Those levels select the kind of transfer for the whole strobe cycle. The row address is taken at the row-strobe fall. Later in the same cycle, the column strobe fall gives the tap point where the next serial access starts. A row copy moves a whole row in one step, from the SAM into the array or from the array into the SAM. A pseudo-write moves no data and only turns the serial port around to input.

The serial side has its own clock. Each rising serial-clock edge moves the tap pointer forward by one and wraps at the SAM length. In input mode the serial data at the pointer is stored; in output mode the SAM word at the pointer is presented. The array is a behavioural register memory whose row count, tap count and word width are parameters. All strobes and the serial clock are levels sampled on `clk_i`. An edge is a change between two consecutive samples, and its effect appears after that clock edge.

Top module: `vxfer_ctrl`

## Requirements
- R1: The transfer type comes from the levels of trg_n_i, we_n_i, se_n_i and dsf_i at the clock where a row-strobe fall is seen. Later changes to these levels within the same strobe cycle have no effect.
- R2: trg_n_i=0, we_n_i=0, dsf_i=0, se_n_i=0 at the row-strobe fall copies the whole SAM into the row given by the low address bits.
- R3: trg_n_i=0, we_n_i=0, dsf_i=1 copies the whole SAM into the addressed row, whatever the level of se_n_i.
- R4: trg_n_i=0, we_n_i=0, dsf_i=0, se_n_i=1 is a pseudo-write. No array row changes, the row address is ignored, and the serial port enters input mode.
- R5: Every write-type cycle (normal, alternate, pseudo) leaves serial_in_o=1.
- R6: trg_n_i=0, we_n_i=1 copies the addressed array row into the SAM and sets serial_in_o=0.
- R7: With trg_n_i=1 at the row-strobe fall, nothing is transferred, the mode is unchanged, and a column-strobe fall in that cycle does not load the tap.
- R8: In a transfer cycle, a column-strobe fall while the row strobe is low loads tap_o from the low address bits.
- R9: Each accepted serial-clock rise advances tap_o by one, wrapping from TAPS-1 to 0. In input mode sdq_i is stored at the old tap. sdq_o always shows the SAM word at tap_o.
- R10: Serial-clock rises while the row strobe is low in a write-type cycle are ignored: the tap and the SAM do not change.
- R11: After reset the port is in output mode, tap_o=0, and the SAM and the array hold zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| trg_n_i | input | 1 | Transfer gate, active low |
| we_n_i | input | 1 | Write enable, active low |
| se_n_i | input | 1 | Serial enable, active low |
| dsf_i | input | 1 | Special-function select |
| addr_i | input | ADDR_W | Row address at row-strobe fall, tap at column-strobe fall |
| sc_i | input | 1 | Serial clock |
| sdq_i | input | DW | Serial input data |
| sdq_o | output | DW | SAM word at the tap pointer |
| serial_in_o | output | 1 | 1 = serial input mode, 0 = output mode |
| tap_o | output | TAW | Tap pointer |

## Verification
The bench builds the block with its defaults: 16 rows, 16 taps and 4-bit words. At that size every row can be written through the SAM and read back through the serial port in full, and every tap position is visited, including the wrap. During each strobe cycle the bench inverts the control levels after the row-strobe fall. This shows that only the latched decode matters. The alternate, pseudo, no-transfer and blocked-serial-clock cases are then checked against the bench's reference array.

// File: rtl/vxfer_pkg.sv
package vxfer_pkg;
  typedef enum logic [2:0] {
    XF_NONE   = 3'd0,
    XF_READ   = 3'd1,
    XF_WRITE  = 3'd2,
    XF_ALT    = 3'd3,
    XF_PSEUDO = 3'd4
  } xfer_e;

  function automatic logic is_wr(xfer_e op);
    return (op == XF_WRITE) || (op == XF_ALT) || (op == XF_PSEUDO);
  endfunction
endpackage

// File: rtl/vxfer_decode.sv
module vxfer_decode
  import vxfer_pkg::*;
(
  input  logic  trg_n_i,
  input  logic  we_n_i,
  input  logic  se_n_i,
  input  logic  dsf_i,
  output xfer_e op_o
);
  always_comb begin
    if (trg_n_i)     op_o = XF_NONE;
    else if (we_n_i) op_o = XF_READ;
    else if (dsf_i)  op_o = XF_ALT;     // SE is don't-care here
    else if (se_n_i) op_o = XF_PSEUDO;
    else             op_o = XF_WRITE;
  end
endmodule

// File: rtl/vxfer_array.sv
module vxfer_array #(
  parameter int ROWS  = 16,
  parameter int ROW_W = 64,
  localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [RAW-1:0]   row_i,
  input  logic [ROW_W-1:0] wdata_i,
  output logic [ROW_W-1:0] rdata_o
);
  logic [ROWS-1:0][ROW_W-1:0] mem_q;

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (wr_en_i && (row_i == RAW'(g)))       mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = (int'(row_i) < ROWS) ? mem_q[row_i] : '0;

  a_r4_only_write_changes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q));
endmodule

// File: rtl/vxfer_sam.sv
module vxfer_sam #(
  parameter int TAPS = 16,
  parameter int DW   = 4,
  localparam int TAW = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ROW_W = TAPS * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [ROW_W-1:0] load_data_i,
  input  logic             tap_load_i,
  input  logic [TAW-1:0]   tap_addr_i,
  input  logic             shift_i,
  input  logic             mode_in_i,
  input  logic [DW-1:0]    sdq_i,
  output logic [ROW_W-1:0] row_o,
  output logic [TAW-1:0]   tap_o,
  output logic [DW-1:0]    sdq_o
);
  logic [TAPS-1:0][DW-1:0] sam_q;
  logic [TAW-1:0]          tap_q;

  for (genvar g = 0; g < TAPS; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sam_q[g] <= '0;
      else if (load_en_i) sam_q[g] <= load_data_i[g*DW +: DW];
      else if (shift_i && mode_in_i && (tap_q == TAW'(g)))
                          sam_q[g] <= sdq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      tap_q <= '0;
    else if (tap_load_i)
      tap_q <= (int'(tap_addr_i) < TAPS) ? tap_addr_i : '0;
    else if (shift_i)
      tap_q <= (int'(tap_q) == TAPS - 1) ? '0 : tap_q + 1'b1;
  end

  assign row_o = sam_q;
  assign tap_o = tap_q;
  assign sdq_o = sam_q[tap_q];

  always_comb a_r9_tap_range: assert (!rst_ni || int'(tap_q) < TAPS);

  a_r10_tap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !tap_load_i) |=> $stable(tap_q));
  a_r9_tap_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !tap_load_i) |=> tap_q != $past(tap_q));
endmodule

// File: rtl/vxfer_ctrl.sv
module vxfer_ctrl
  import vxfer_pkg::*;
#(
  parameter int ROWS = 16,
  parameter int TAPS = 16,
  parameter int DW   = 4,
  parameter int ADDR_W = ($clog2(ROWS) > $clog2(TAPS)) ? $clog2(ROWS) : $clog2(TAPS),
  localparam int RAW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TAW = (TAPS > 1) ? $clog2(TAPS) : 1,
  localparam int ROW_W = TAPS * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic              cas_n_i,
  input  logic              trg_n_i,
  input  logic              we_n_i,
  input  logic              se_n_i,
  input  logic              dsf_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sc_i,
  input  logic [DW-1:0]     sdq_i,
  output logic [DW-1:0]     sdq_o,
  output logic              serial_in_o,
  output logic [TAW-1:0]    tap_o
);
  logic  ras_q, cas_q, sc_q, mode_q;
  xfer_e op_d, op_q;
  logic  ras_fall, ras_rise, cas_fall, sc_rise;
  logic  blk, arr_wr, sam_ld, tap_ld, shift;
  logic [ROW_W-1:0] sam_row, arr_row;

  vxfer_decode u_dec (
    .trg_n_i(trg_n_i), .we_n_i(we_n_i), .se_n_i(se_n_i), .dsf_i(dsf_i), .op_o(op_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      sc_q  <= 1'b0;
    end else begin
      ras_q <= ras_n_i;
      cas_q <= cas_n_i;
      sc_q  <= sc_i;
    end
  end

  assign ras_fall = ras_q && !ras_n_i;
  assign ras_rise = !ras_q && ras_n_i;
  assign cas_fall = cas_q && !cas_n_i && !ras_q && !ras_n_i;
  assign sc_rise  = sc_i && !sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       op_q <= XF_NONE;
    else if (ras_fall) op_q <= op_d;
    else if (ras_rise) op_q <= XF_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          mode_q <= 1'b0;
    else if (ras_fall && is_wr(op_d))     mode_q <= 1'b1;
    else if (ras_fall && op_d == XF_READ) mode_q <= 1'b0;
  end

  // serial clock frozen while a write transfer holds the row strobe low
  assign blk    = ras_fall ? is_wr(op_d) : (is_wr(op_q) && !ras_n_i);
  assign arr_wr = ras_fall && (op_d == XF_WRITE || op_d == XF_ALT);
  assign sam_ld = ras_fall && (op_d == XF_READ);
  assign tap_ld = cas_fall && (op_q != XF_NONE);
  assign shift  = sc_rise && !blk;

  vxfer_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_arr (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(arr_wr),
    .row_i(addr_i[RAW-1:0]), .wdata_i(sam_row), .rdata_o(arr_row)
  );

  vxfer_sam #(.TAPS(TAPS), .DW(DW)) u_sam (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_en_i(sam_ld), .load_data_i(arr_row),
    .tap_load_i(tap_ld), .tap_addr_i(addr_i[TAW-1:0]), .shift_i(shift),
    .mode_in_i(mode_q), .sdq_i(sdq_i), .row_o(sam_row), .tap_o(tap_o), .sdq_o(sdq_o)
  );

  assign serial_in_o = mode_q;

  a_r5_write_sets_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && !trg_n_i && !we_n_i) |=> serial_in_o);
  a_r6_read_sets_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && !trg_n_i && we_n_i) |=> !serial_in_o);
  a_r7_idle_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_fall && trg_n_i) |=> $stable(serial_in_o));
  a_r8_tap_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_ld && int'(addr_i[TAW-1:0]) < TAPS) |=> tap_o == $past(addr_i[TAW-1:0]));
  a_r10_blocked_sc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_rise && blk && !tap_ld) |=> ($stable(tap_o) && $stable(sam_row)));
endmodule

// File: tb/vxfer_ctrl_test.sv
module vxfer_ctrl_test;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1, cas_n = 1, trg_n = 1, we_n = 1, se_n = 1, dsf = 0, sc = 0;
  logic [3:0] addr = '0, sdq_in = '0;
  logic [3:0] sdq_out, tap;
  logic       s_in;

  int errors = 0, checks = 0;
  bit done = 0;
  int ref_mem [N][N];
  int ref_sam [N];
  int ref_tap = 0, ref_mode = 0;

  always #10 clk = ~clk;

  vxfer_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .ras_n_i(ras_n), .cas_n_i(cas_n), .trg_n_i(trg_n),
    .we_n_i(we_n), .se_n_i(se_n), .dsf_i(dsf), .addr_i(addr), .sc_i(sc),
    .sdq_i(sdq_in), .sdq_o(sdq_out), .serial_in_o(s_in), .tap_o(tap)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sc_pulse(input int d, input string req);
    @(negedge clk); sc = 1; sdq_in = 4'(d);
    @(negedge clk); sc = 0;
    if (ref_mode == 1) ref_sam[ref_tap] = d;
    ref_tap = (ref_tap + 1) % N;
    check(req, int'(tap), ref_tap);
  endtask

  // one strobe cycle; controls are inverted after the row-strobe fall
  task automatic ras_cycle(input bit t, input bit w, input bit s, input bit f,
                           input int row, input int tp, input bit sc_mid);
    @(negedge clk); trg_n = t; we_n = w; se_n = s; dsf = f; addr = 4'(row); ras_n = 0;
    @(negedge clk); trg_n = !t; we_n = !w; se_n = !s; dsf = !f; addr = 4'(tp); cas_n = 0;
    if (sc_mid) begin
      @(negedge clk); sc = 1; sdq_in = 4'hF;
      @(negedge clk); sc = 0;
    end
    @(negedge clk); ras_n = 1; cas_n = 1; trg_n = 1; we_n = 1; se_n = 1; dsf = 0;
    @(negedge clk);
    if (!t) begin
      if (!w) begin
        if (f || !s) for (int i = 0; i < N; i++) ref_mem[row][i] = ref_sam[i];
        ref_mode = 1;
      end else begin
        for (int i = 0; i < N; i++) ref_sam[i] = ref_mem[row][i];
        ref_mode = 0;
      end
      ref_tap = tp;
    end
  endtask

  task automatic fill_sam(input int seed);
    ras_cycle(0, 0, 1, 0, 3, 0, 0);
    check("R4 pseudo sets input", int'(s_in), 1);
    for (int i = 0; i < N; i++) sc_pulse((seed + i * 5) % 16, "R9 input shift");
  endtask

  task automatic read_row(input int r, input int tp);
    ras_cycle(0, 1, 0, 0, r, tp, 0);
    check("R6 read sets output", int'(s_in), 0);
    check("R8 tap load", int'(tap), tp);
    for (int i = 0; i < N; i++) begin
      check($sformatf("R6 row %0d data", r), int'(sdq_out), ref_sam[ref_tap]);
      sc_pulse(0, "R9 output shift wrap");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < N; r++) begin
      ref_sam[r] = 0;
      for (int i = 0; i < N; i++) ref_mem[r][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset tap", int'(tap), 0);
    check("R11 reset mode", int'(s_in), 0);
    check("R11 reset sam", int'(sdq_out), 0);
    read_row(9, 0);  // R11 array zero

    // R2 normal write to every row, R1 via inverted controls mid-cycle
    for (int r = 0; r < N; r++) begin
      fill_sam(r * 3 + 1);
      ras_cycle(0, 0, 0, 0, r, (r * 7) % N, 0);
      check("R1 latched decode mode", int'(s_in), 1);
      check("R5 write leaves input", int'(s_in), 1);
      check("R8 tap after write", int'(tap), (r * 7) % N);
    end
    for (int r = 0; r < N; r++) read_row(r, r);  // R2 readback

    // R3 alternate write with SE high
    fill_sam(11);
    ras_cycle(0, 0, 1, 1, 5, 2, 0);
    check("R3 alternate mode", int'(s_in), 1);
    read_row(5, 0);

    // R4 pseudo-write leaves array untouched
    fill_sam(4);
    ras_cycle(0, 0, 1, 0, 7, 0, 0);
    check("R5 pseudo leaves input", int'(s_in), 1);
    read_row(7, 3);

    // R7 no-transfer cycle: tap and mode unchanged
    ras_cycle(0, 1, 0, 0, 2, 6, 0);
    ras_cycle(1, 0, 0, 0, 2, 9, 0);
    check("R7 tap kept", int'(tap), 6);
    check("R7 mode kept", int'(s_in), 0);
    check("R7 sam kept", int'(sdq_out), ref_sam[6]);

    // R10 serial clock ignored during a write transfer
    fill_sam(8);
    ras_cycle(0, 0, 0, 0, 12, 4, 1);
    check("R10 tap frozen", int'(tap), 4);
    check("R10 sam word", int'(sdq_out), ref_sam[4]);
    read_row(12, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule